// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the processor's side of accepting a hardware interrupt. It sits idle until an interrupt request is pending and the instruction in flight reports completion. It then captures the request's number, level and service-select bit, along with a snapshot of the register file. A set service-select bit hands the request to a separate service path, and the sequencer drops back to idle without touching memory.

For an ordinary interrupt, the sequencer pushes the saved context onto the system stack one byte per cycle through a byte-wide memory port. It then reads three vector bytes from the fixed vector table at the top of the address space. It finishes with a single-cycle load strobe that carries the new program counter, program bank, stack pointer and interrupt level mask to the register file.

The memory read latency (zero or one cycle) and the field widths are parameters. The vector table spans the top 1 KiB of a 24-bit space.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `busy`, `done`, `alt_take`, `mem_we` and `mem_re` are low. A sequence is accepted only on a clock edge where the sequencer is idle and both `irq_valid` and `insn_done` are high.
- R2: When the captured service-select bit is 1, the cycle after acceptance shows `alt_take` high with `busy` high and no memory access, and the sequencer is idle on the following cycle. Nothing is written, read or loaded.
- R3: When the service-select bit is 0, exactly 12 consecutive write cycles follow the check cycle. Write k (k = 1..12) goes to address {SSB, SSP - k}, with the stack pointer part wrapping modulo 2^16 and the bank part unchanged. SSB and SSP are the stack bank and stack pointer captured at acceptance.
- R4: The 12 bytes are written in this order: status word high byte, then low byte; program counter high byte, then low byte; program bank; data bank; additional bank; direct page; then the 32-bit accumulator from bits 31:24 down to bits 7:0. All values are those captured at acceptance.
- R5: After the pushes, three reads are issued on consecutive cycles at B, B+1 and B+2, where B = FFFFFCh - 4 * interrupt number. Every read address lies in FFFC00h..FFFFFFh.
- R6: On the `done` cycle, `new_pc` equals {byte at B+1, byte at B} and `new_pcb` equals the byte at B+2.
- R7: On the `done` cycle, `new_ilm` equals the level of the accepted request.
- R8: On the `done` cycle, `new_ssp` equals the captured SSP minus 12, modulo 2^16.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. `done` is a one-cycle pulse followed by an idle cycle. Request and register inputs that change while busy have no effect on the running sequence.
- R10: With one-cycle read latency, `done` is high in the 18th cycle after the accepting edge: 1 check cycle, 12 push cycles, 4 vector cycles and 1 load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | An interrupt request is pending and allowed |
| irq_num | input | NUM_W | Number of the winning request |
| irq_level | input | LVL_W | Level of the winning request |
| irq_svc_sel | input | 1 | Service-select bit of the winning request (1 = alternative path) |
| insn_done | input | 1 | The current instruction has completed |
| reg_ps | input | PS_W | Status word |
| reg_pc | input | PC_W | Program counter |
| reg_pcb | input | BANK_W | Program bank |
| reg_dtb | input | BANK_W | Data bank |
| reg_adb | input | BANK_W | Additional bank |
| reg_dpr | input | BANK_W | Direct page |
| reg_acc | input | ACC_W | Accumulator |
| reg_ssb | input | BANK_W | System stack bank |
| reg_ssp | input | PC_W | System stack pointer |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_addr | output | BANK_W+PC_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, RD_LAT cycles after `mem_re` |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Load strobe and completion pulse |
| alt_take | output | 1 | Request handed to the alternative service path |
| new_pc | output | PC_W | Program counter to load |
| new_pcb | output | BANK_W | Program bank to load |
| new_ilm | output | LVL_W | Interrupt level mask to load |
| new_ssp | output | PC_W | Stack pointer to load |

## Verification
Counting from the edge that accepts a request, the check cycle appears one cycle later. The pushes follow in cycles 2 to 13, the three reads in cycles 14 to 16, the read-data wait in cycle 17 and the load strobe in cycle 18. A handed-off request shows `alt_take` in cycle 1 and is idle in cycle 2. The bench model builds this whole timeline as a queue of per-cycle expectations at the moment it sees the accepting inputs. It pops one entry at each falling edge and compares the outputs half a cycle after the edge that produced them, so every result is judged in the cycle it is due and never one early or late.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_CHECK,
      SEQ_PUSH,
      SEQ_VEC,
      SEQ_LOAD
   } seq_state_e;

   localparam int unsigned VEC_BYTES = 3;

endpackage

// File: rtl/irq_ctx_pick.sv
module irq_ctx_pick #(
   parameter int unsigned PS_W   = 16,
   parameter int unsigned PC_W   = 16,
   parameter int unsigned BANK_W = 8,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned IDX_W  = 4
) (
   input  logic [PS_W-1:0]   ps,
   input  logic [PC_W-1:0]   pc,
   input  logic [BANK_W-1:0] pcb,
   input  logic [BANK_W-1:0] dtb,
   input  logic [BANK_W-1:0] adb,
   input  logic [BANK_W-1:0] dpr,
   input  logic [ACC_W-1:0]  acc,
   input  logic [IDX_W-1:0]  idx,
   output logic [7:0]        byte_o
);

   localparam int unsigned CTX_W     = PS_W + PC_W + 4 * BANK_W + ACC_W;
   localparam int unsigned CTX_BYTES = CTX_W / 8;

   if ((CTX_W % 8) != 0) begin : g_bad_width
      $error("context width must be a whole number of bytes");
   end
   if ((1 << IDX_W) < CTX_BYTES) begin : g_bad_idx
      $error("index too narrow for the context");
   end

   logic [CTX_W-1:0] flat;
   logic [7:0]       slot [CTX_BYTES];

   assign flat = {ps, pc, pcb, dtb, adb, dpr, acc};

   // slot 0 is the first byte pushed: the most significant byte of the status word
   for (genvar g = 0; g < CTX_BYTES; g++) begin : g_slot
      assign slot[g] = flat[CTX_W-1-8*g -: 8];
   end

   always_comb begin
      byte_o = '0;
      for (int i = 0; i < CTX_BYTES; i++) begin
         if (idx == IDX_W'(i)) byte_o = slot[i];
      end
   end

endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned NUM_W      = 8,
   parameter int unsigned TABLE_SPAN = 1024
) (
   input  logic [NUM_W-1:0]  num,
   input  logic [1:0]        idx,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] ALL_ONES = '1;
   localparam logic [ADDR_W-1:0] VEC_TOP  = ALL_ONES - ADDR_W'(3);

   if ((NUM_W + 2) > ADDR_W) begin : g_bad_num
      $error("interrupt number too wide for the address");
   end
   if ((4 * (1 << NUM_W)) > TABLE_SPAN) begin : g_bad_span
      $error("vector table span cannot hold every interrupt number");
   end

   logic [ADDR_W-1:0] slot_off;
   logic [ADDR_W-1:0] base;

   assign slot_off = ADDR_W'({num, 2'b00});
   assign base     = VEC_TOP - slot_off;
   assign addr     = base + ADDR_W'(idx);

endmodule

// File: rtl/irq_vec_collect.sv
module irq_vec_collect #(
   parameter int unsigned PC_W   = 16,
   parameter int unsigned BANK_W = 8,
   parameter int unsigned RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [1:0]        rd_idx,
   input  logic [7:0]        rd_data,
   output logic [PC_W-1:0]   pc_o,
   output logic [BANK_W-1:0] pcb_o
);

   logic       cap_en;
   logic [1:0] cap_idx;

   if (RD_LAT == 0) begin : g_comb_rd
      assign cap_en  = rd_en;
      assign cap_idx = rd_idx;
   end else begin : g_reg_rd
      logic       en_q;
      logic [1:0] idx_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q  <= 1'b0;
            idx_q <= '0;
         end else begin
            en_q  <= rd_en;
            idx_q <= rd_idx;
         end
      end
      assign cap_en  = en_q;
      assign cap_idx = idx_q;
   end

   logic [7:0] vb [3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) vb[i] <= '0;
      end else if (cap_en && cap_idx != 2'd3) begin
         vb[cap_idx] <= rd_data;
      end
   end

   assign pc_o  = {vb[1], vb[0]};
   assign pcb_o = vb[2];

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int unsigned NUM_W      = 8,
   parameter int unsigned LVL_W      = 3,
   parameter int unsigned PS_W       = 16,
   parameter int unsigned PC_W       = 16,
   parameter int unsigned BANK_W     = 8,
   parameter int unsigned ACC_W      = 32,
   parameter int unsigned RD_LAT     = 1,
   parameter int unsigned TABLE_SPAN = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     irq_valid,
   input  logic [NUM_W-1:0]         irq_num,
   input  logic [LVL_W-1:0]         irq_level,
   input  logic                     irq_svc_sel,
   input  logic                     insn_done,
   input  logic [PS_W-1:0]          reg_ps,
   input  logic [PC_W-1:0]          reg_pc,
   input  logic [BANK_W-1:0]        reg_pcb,
   input  logic [BANK_W-1:0]        reg_dtb,
   input  logic [BANK_W-1:0]        reg_adb,
   input  logic [BANK_W-1:0]        reg_dpr,
   input  logic [ACC_W-1:0]         reg_acc,
   input  logic [BANK_W-1:0]        reg_ssb,
   input  logic [PC_W-1:0]          reg_ssp,
   output logic                     mem_we,
   output logic                     mem_re,
   output logic [BANK_W+PC_W-1:0]   mem_addr,
   output logic [7:0]               mem_wdata,
   input  logic [7:0]               mem_rdata,
   output logic                     busy,
   output logic                     done,
   output logic                     alt_take,
   output logic [PC_W-1:0]          new_pc,
   output logic [BANK_W-1:0]        new_pcb,
   output logic [LVL_W-1:0]         new_ilm,
   output logic [PC_W-1:0]          new_ssp
);

   localparam int unsigned ADDR_W    = BANK_W + PC_W;
   localparam int unsigned CTX_BYTES = (PS_W + PC_W + 4 * BANK_W + ACC_W) / 8;
   localparam int unsigned VEC_CYC   = VEC_BYTES + RD_LAT;
   localparam int unsigned CNT_MAX   = (CTX_BYTES > VEC_CYC) ? CTX_BYTES : VEC_CYC;
   localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

   if (PC_W != 16 || BANK_W != 8) begin : g_bad_vec
      $error("a three-byte vector needs a 16-bit counter and an 8-bit bank");
   end
   if (RD_LAT > 1) begin : g_bad_lat
      $error("read latency must be 0 or 1");
   end
   if ((PS_W % 8) != 0 || (ACC_W % 8) != 0) begin : g_bad_ctx
      $error("status and accumulator widths must be whole bytes");
   end
   if (LVL_W == 0 || NUM_W == 0) begin : g_bad_req
      $error("request fields must be at least one bit wide");
   end

   seq_state_e         state;
   logic [CNT_W-1:0]   cnt;
   logic [NUM_W-1:0]   num_q;
   logic [LVL_W-1:0]   lvl_q;
   logic               sel_q;
   logic [PS_W-1:0]    ps_q;
   logic [PC_W-1:0]    pc_q;
   logic [BANK_W-1:0]  pcb_q, dtb_q, adb_q, dpr_q, ssb_q;
   logic [ACC_W-1:0]   acc_q;
   logic [PC_W-1:0]    ssp_q;

   logic               take;
   logic               push_last, vec_last;

   assign take      = (state == SEQ_IDLE) && irq_valid && insn_done;
   assign push_last = (cnt == CNT_W'(CTX_BYTES - 1));
   assign vec_last  = (cnt == CNT_W'(VEC_CYC - 1));

   // sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               cnt <= '0;
               if (take) state <= SEQ_CHECK;
            end
            SEQ_CHECK: begin
               cnt   <= '0;
               state <= sel_q ? SEQ_IDLE : SEQ_PUSH;
            end
            SEQ_PUSH: begin
               if (push_last) begin
                  cnt   <= '0;
                  state <= SEQ_VEC;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_VEC: begin
               if (vec_last) begin
                  cnt   <= '0;
                  state <= SEQ_LOAD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_LOAD: begin
               cnt   <= '0;
               state <= SEQ_IDLE;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // snapshot of request and register file at acceptance
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         num_q <= '0;
         lvl_q <= '0;
         sel_q <= 1'b0;
         ps_q  <= '0;
         pc_q  <= '0;
         pcb_q <= '0;
         dtb_q <= '0;
         adb_q <= '0;
         dpr_q <= '0;
         acc_q <= '0;
         ssb_q <= '0;
         ssp_q <= '0;
      end else if (take) begin
         num_q <= irq_num;
         lvl_q <= irq_level;
         sel_q <= irq_svc_sel;
         ps_q  <= reg_ps;
         pc_q  <= reg_pc;
         pcb_q <= reg_pcb;
         dtb_q <= reg_dtb;
         adb_q <= reg_adb;
         dpr_q <= reg_dpr;
         acc_q <= reg_acc;
         ssb_q <= reg_ssb;
         ssp_q <= reg_ssp;
      end
   end

   logic [7:0]        push_byte;
   logic [ADDR_W-1:0] vec_addr;
   logic [PC_W-1:0]   push_sp;
   logic              vec_rd;

   irq_ctx_pick #(
      .PS_W  (PS_W),
      .PC_W  (PC_W),
      .BANK_W(BANK_W),
      .ACC_W (ACC_W),
      .IDX_W (CNT_W)
   ) u_pick (
      .ps    (ps_q),
      .pc    (pc_q),
      .pcb   (pcb_q),
      .dtb   (dtb_q),
      .adb   (adb_q),
      .dpr   (dpr_q),
      .acc   (acc_q),
      .idx   (cnt),
      .byte_o(push_byte)
   );

   irq_vec_addr #(
      .ADDR_W    (ADDR_W),
      .NUM_W     (NUM_W),
      .TABLE_SPAN(TABLE_SPAN)
   ) u_vaddr (
      .num (num_q),
      .idx (cnt[1:0]),
      .addr(vec_addr)
   );

   irq_vec_collect #(
      .PC_W  (PC_W),
      .BANK_W(BANK_W),
      .RD_LAT(RD_LAT)
   ) u_collect (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (vec_rd),
      .rd_idx (cnt[1:0]),
      .rd_data(mem_rdata),
      .pc_o   (new_pc),
      .pcb_o  (new_pcb)
   );

   // pre-decremented stack address: write k uses SSP - k
   assign push_sp = ssp_q - (PC_W'(cnt) + PC_W'(1));
   assign vec_rd  = (state == SEQ_VEC) && (cnt < CNT_W'(VEC_BYTES));

   always_comb begin
      mem_we    = (state == SEQ_PUSH);
      mem_re    = vec_rd;
      mem_wdata = push_byte;
      mem_addr  = mem_we ? {ssb_q, push_sp} : vec_addr;
   end

   assign busy     = (state != SEQ_IDLE);
   assign done     = (state == SEQ_LOAD);
   assign alt_take = (state == SEQ_CHECK) && sel_q;
   assign new_ilm  = lvl_q;
   assign new_ssp  = ssp_q - PC_W'(CTX_BYTES);

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned PC_W       = 16,
   parameter int unsigned TABLE_SPAN = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_valid,
   input logic              insn_done,
   input logic              busy,
   input logic              done,
   input logic              alt_take,
   input logic              mem_we,
   input logic              mem_re,
   input logic [ADDR_W-1:0] mem_addr
);

   localparam logic [ADDR_W-1:0] ALL_ONES   = '1;
   localparam logic [ADDR_W-1:0] TABLE_BASE = ALL_ONES - ADDR_W'(TABLE_SPAN - 1);
   localparam logic [PC_W-1:0]   ONE        = 1;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re && !done && !alt_take));

   assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(irq_valid && insn_done));

   assert_alt_noaccess_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alt_take |-> (!mem_we && !mem_re && !done));

   assert_alt_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alt_take |=> !busy);

   assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |->
         (mem_addr[PC_W-1:0] == $past(mem_addr[PC_W-1:0]) - ONE &&
          mem_addr[ADDR_W-1:PC_W] == $past(mem_addr[ADDR_W-1:PC_W])));

   assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> (mem_addr >= TABLE_BASE));

   assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_single_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
   .ADDR_W    (BANK_W + PC_W),
   .PC_W      (PC_W),
   .TABLE_SPAN(TABLE_SPAN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_valid(irq_valid),
   .insn_done(insn_done),
   .busy     (busy),
   .done     (done),
   .alt_take (alt_take),
   .mem_we   (mem_we),
   .mem_re   (mem_re),
   .mem_addr (mem_addr)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_valid = 1'b0;
   logic [7:0]  irq_num = '0;
   logic [2:0]  irq_level = '0;
   logic        irq_svc_sel = 1'b0;
   logic        insn_done = 1'b0;
   logic [15:0] reg_ps = '0;
   logic [15:0] reg_pc = '0;
   logic [7:0]  reg_pcb = '0, reg_dtb = '0, reg_adb = '0, reg_dpr = '0, reg_ssb = '0;
   logic [31:0] reg_acc = '0;
   logic [15:0] reg_ssp = '0;
   logic        mem_we, mem_re, busy, done, alt_take;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic [15:0] new_pc, new_ssp;
   logic [7:0]  new_pcb;
   logic [2:0]  new_ilm;

   always #2 clk = ~clk;

   irq_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_num(irq_num),
      .irq_level(irq_level), .irq_svc_sel(irq_svc_sel), .insn_done(insn_done),
      .reg_ps(reg_ps), .reg_pc(reg_pc), .reg_pcb(reg_pcb), .reg_dtb(reg_dtb),
      .reg_adb(reg_adb), .reg_dpr(reg_dpr), .reg_acc(reg_acc), .reg_ssb(reg_ssb),
      .reg_ssp(reg_ssp), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .alt_take(alt_take), .new_pc(new_pc), .new_pcb(new_pcb), .new_ilm(new_ilm),
      .new_ssp(new_ssp)
   );

   // vector table contents, a fixed function of the address
   function automatic logic [7:0] tbl(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
   endfunction

   // memory with one cycle of read latency
   always @(posedge clk) begin
      mem_rdata <= mem_re ? tbl(mem_addr) : 8'h00;
   end

   typedef struct packed {
      logic        busy;
      logic        alt;
      logic        we;
      logic        re;
      logic        done;
      logic [23:0] addr;
      logic [7:0]  wdata;
      logic [15:0] pc;
      logic [7:0]  pcb;
      logic [2:0]  ilm;
      logic [15:0] ssp;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   cur_idle = 1'b1;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // queue the full expected timeline for a request accepted now
   task automatic build();
      exp_t        e;
      logic [7:0]  b [12];
      logic [23:0] base;
      e = '0;
      e.busy = 1'b1;
      e.alt  = irq_svc_sel;
      q.push_back(e);
      if (irq_svc_sel) return;
      b[0]  = reg_ps[15:8];  b[1]  = reg_ps[7:0];
      b[2]  = reg_pc[15:8];  b[3]  = reg_pc[7:0];
      b[4]  = reg_pcb;       b[5]  = reg_dtb;
      b[6]  = reg_adb;       b[7]  = reg_dpr;
      b[8]  = reg_acc[31:24]; b[9]  = reg_acc[23:16];
      b[10] = reg_acc[15:8];  b[11] = reg_acc[7:0];
      for (int k = 0; k < 12; k++) begin
         e = '0;
         e.busy  = 1'b1;
         e.we    = 1'b1;
         e.addr  = {reg_ssb, 16'(reg_ssp - 16'(k + 1))};
         e.wdata = b[k];
         q.push_back(e);
      end
      base = 24'hFFFFFC - 24'(int'(irq_num) * 4);
      for (int i = 0; i < 3; i++) begin
         e = '0;
         e.busy = 1'b1;
         e.re   = 1'b1;
         e.addr = base + 24'(i);
         q.push_back(e);
      end
      e = '0;
      e.busy = 1'b1;
      q.push_back(e);
      e = '0;
      e.busy = 1'b1;
      e.done = 1'b1;
      e.pc   = {tbl(base + 24'd1), tbl(base)};
      e.pcb  = tbl(base + 24'd2);
      e.ilm  = irq_level;
      e.ssp  = reg_ssp - 16'd12;
      q.push_back(e);
   endtask

   task automatic compare(input exp_t e);
      chk("R9", "busy", 32'(busy), 32'(e.busy));
      chk("R2", "alt_take", 32'(alt_take), 32'(e.alt));
      chk("R3", "mem_we", 32'(mem_we), 32'(e.we));
      chk("R5", "mem_re", 32'(mem_re), 32'(e.re));
      chk("R10", "done", 32'(done), 32'(e.done));
      if (e.we) begin
         chk("R3", "push address", 32'(mem_addr), 32'(e.addr));
         chk("R4", "push byte", 32'(mem_wdata), 32'(e.wdata));
      end
      if (e.re) chk("R5", "vector address", 32'(mem_addr), 32'(e.addr));
      if (e.done) begin
         chk("R6", "new_pc", 32'(new_pc), 32'(e.pc));
         chk("R6", "new_pcb", 32'(new_pcb), 32'(e.pcb));
         chk("R7", "new_ilm", 32'(new_ilm), 32'(e.ilm));
         chk("R8", "new_ssp", 32'(new_ssp), 32'(e.ssp));
      end
   endtask

   // one clock: decide acceptance from the inputs now driven, then compare
   task automatic cycle();
      exp_t e;
      if (cur_idle && irq_valid && insn_done) build();
      @(negedge clk);
      if (q.size() == 0) begin
         e = '0;
         cur_idle = 1'b1;
      end else begin
         e = q.pop_front();
         cur_idle = 1'b0;
      end
      compare(e);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic set_regs(input logic [15:0] ps, input logic [15:0] pc,
                           input logic [31:0] acc, input logic [15:0] ssp,
                           input logic [7:0] ssb);
      reg_ps  = ps;
      reg_pc  = pc;
      reg_acc = acc;
      reg_ssp = ssp;
      reg_ssb = ssb;
      reg_pcb = pc[7:0] ^ 8'h11;
      reg_dtb = pc[15:8] ^ 8'h22;
      reg_adb = ps[7:0] ^ 8'h33;
      reg_dpr = ps[15:8] ^ 8'h44;
   endtask

   task automatic request(input logic [7:0] num, input logic [2:0] lvl, input logic sel);
      irq_num     = num;
      irq_level   = lvl;
      irq_svc_sel = sel;
      irq_valid   = 1'b1;
      insn_done   = 1'b1;
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "busy after reset", 32'(busy), 32'd0);
      chk("R1", "done after reset", 32'(done), 32'd0);
      chk("R1", "mem_we after reset", 32'(mem_we), 32'd0);
      chk("R1", "mem_re after reset", 32'(mem_re), 32'd0);

      // R1: pending request but instruction not finished
      irq_valid = 1'b1;
      insn_done = 1'b0;
      run(4);
      chk("R1", "busy without insn_done", 32'(busy), 32'd0);

      // R3 R4 R5 R6 R7 R8 R10: ordinary entry; registers change after acceptance (R9)
      set_regs(16'hC3A5, 16'h1234, 32'hDEADBEEF, 16'h0800, 8'h0F);
      request(8'd5, 3'd3, 1'b0);
      run(1);
      irq_valid = 1'b0;
      set_regs(16'h0000, 16'hFFFF, 32'h0, 16'h0000, 8'hAA);
      irq_num = 8'd77;
      irq_level = 3'd6;
      run(19);

      // R9: request held through a sequence is ignored until idle, then taken again
      set_regs(16'h8001, 16'hBEEF, 32'h01234567, 16'h4000, 8'h01);
      request(8'd17, 3'd6, 1'b0);
      run(1);
      set_regs(16'h7E7E, 16'h0102, 32'h89ABCDEF, 16'h2222, 8'h3C);
      irq_num = 8'd40;
      irq_level = 3'd2;
      run(18);
      irq_valid = 1'b0;
      run(20);

      // R2: service-select set hands off without memory traffic
      request(8'd9, 3'd1, 1'b1);
      run(1);
      irq_valid = 1'b0;
      irq_svc_sel = 1'b0;
      run(4);
      chk("R2", "idle after hand-off", 32'(busy), 32'd0);

      // R3 R5: stack pointer wraps, highest vector slot
      set_regs(16'h5A5A, 16'hCAFE, 32'hFEDCBA98, 16'h0005, 8'h7F);
      request(8'd0, 3'd7, 1'b0);
      run(1);
      irq_valid = 1'b0;
      run(20);

      // R5: lowest vector slot at the table base
      set_regs(16'h0F0F, 16'h00FF, 32'h00000001, 16'hFFF0, 8'hFF);
      request(8'd255, 3'd0, 1'b0);
      run(1);
      irq_valid = 1'b0;
      run(20);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule